// File: doc/BRIEF.md
# Dual-Modulus Prescaler Counter

This block divides a fast input clock by one of two neighbouring integers chosen by a one-bit mode input. A fast synchronous front counter divides by its normal ratio or by an alternate ratio that is one count away. A slower back-end counter, built as a chain of toggle stages, advances once per front-counter period. The front counter takes its alternate length only during the last front period of each output period, while every back-end bit is at its terminal value. That period is used only when the latched mode asks for it, so the alternate length occurs at most once per output period.

With the default parameters (normal 4, alternate 5, back end 5 bits) the block divides by 128 with mode 0 and by 129 with mode 1. A small variant (normal 4, alternate 3, alternate on mode 0, back end 2 bits) divides by 15 with mode 0 and by 16 with mode 1. The mode is sampled during reset and again at each output-period boundary, so a mode change never alters a period that is already running. The outputs are the divided clock, which is the back-end MSB, and a one-cycle terminal pulse in the last input cycle of every output period.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With the default parameters and the mode latched at 0, each output period lasts exactly 128 input clock cycles.
- R2: With the default parameters and the mode latched at 1, each output period lasts exactly 129 input clock cycles: one front period of 5 cycles and thirty-one of 4.
- R3: The small variant lasts 15 cycles per period with mode 0 (one front period of 3, three of 4) and 16 cycles with mode 1.
- R4: The alternate-length front period is always the last one in the output period, so `div_clk` rises exactly HALF cycles after the period starts (HALF = normal ratio × 2^(back bits − 1): 64 by default, 8 for the small variant).
- R5: The mode input is sampled only at the clock edge that ends an output period (and during reset). A change at any other time affects only the next period.
- R6: Synchronous active-high reset clears every counter bit, so `div_clk` and `tc_pulse` are 0 while reset is held. The first period after reset has the full length selected by the mode present at reset.
- R7: `tc_pulse` is high for exactly one input cycle, the last cycle of every output period.
- R8: `div_clk` is low in the first cycle of every output period (it falls at the period boundary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Ratio select, latched at period boundaries |
| div_clk | output | 1 | Divided clock (back-end MSB) |
| tc_pulse | output | 1 | One-cycle pulse in the last cycle of each output period |

## Verification
The bench counts input cycles between terminal pulses on both the default and the small variant. It toggles the mode at random points, including the cycle right after a boundary. A design that swallowed the extra count in the wrong back-end state would still give the right period length, but the rise of the divided clock would move off its fixed offset. A design that sampled the mode at once would produce a period of mixed length after a mid-period change. Resets in the middle of a period check that no partial count survives and that the first period has full length. Periods that miss a terminal pulse, or carry more than one, are reported as length errors.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    // Signals exchanged between the stages of one prescaler.
    typedef struct packed {
        logic front_tick;   // front counter at its last count
        logic back_last;    // every back-end bit at terminal value
        logic back_msb;     // divided clock
    } dmp_state_t;

    typedef enum logic {
        LEN_NORMAL = 1'b0,
        LEN_ALT    = 1'b1
    } front_len_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Input cycles in one output period for a given latched mode.
    function automatic int unsigned period_cycles(
        input int unsigned norm_div,
        input int unsigned alt_div,
        input int unsigned back_bits,
        input logic        alt_on_mode,
        input logic        mode_val
    );
        int unsigned base;
        base = norm_div << back_bits;
        if (mode_val == alt_on_mode)
            return base - norm_div + alt_div;
        return base;
    endfunction

endpackage

// File: rtl/dmp_front.sv
module dmp_front
    import dmp_pkg::*;
#(
    parameter int unsigned NORM_DIV = 4,
    parameter int unsigned ALT_DIV  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  front_len_e len_sel,
    output logic       tick
);
    localparam int unsigned MAXD = max_of(NORM_DIV, ALT_DIV);
    localparam int unsigned W    = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    always_comb begin
        lim  = (len_sel == LEN_ALT) ? W'(ALT_DIV - 1) : W'(NORM_DIV - 1);
        tick = (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dmp_back.sv
module dmp_back #(
    parameter int unsigned BACK_BITS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic last,
    output logic msb
);
    logic [BACK_BITS-1:0] q;
    logic [BACK_BITS-1:0] carry;

    assign carry[0] = step;

    for (genvar i = 0; i < BACK_BITS; i++) begin : g_tog
        if (i < BACK_BITS - 1) begin : g_chain
            assign carry[i+1] = carry[i] & q[i];
        end
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (carry[i])
                q[i] <= ~q[i];
        end
    end

    assign last = &q;
    assign msb  = q[BACK_BITS-1];
endmodule

// File: rtl/dmp_mode_latch.sv
module dmp_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic mode_in,
    input  logic boundary,
    output logic mode_q
);
    always_ff @(posedge clk) begin
        if (rst || boundary)
            mode_q <= mode_in;
    end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler
    import dmp_pkg::*;
#(
    parameter int unsigned NORM_DIV    = 4,
    parameter int unsigned ALT_DIV     = 5,
    parameter bit          ALT_ON_MODE = 1'b1,
    parameter int unsigned BACK_BITS   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mode,
    output logic div_clk,
    output logic tc_pulse
);
    dmp_state_t st;
    front_len_e len_sel;
    logic       mode_q;
    logic       boundary;

    always_comb begin
        len_sel  = (st.back_last && (mode_q == ALT_ON_MODE)) ? LEN_ALT : LEN_NORMAL;
        boundary = st.front_tick && st.back_last;
    end

    dmp_front #(.NORM_DIV(NORM_DIV), .ALT_DIV(ALT_DIV)) u_front (
        .clk     (clk),
        .rst     (rst),
        .len_sel (len_sel),
        .tick    (st.front_tick)
    );

    dmp_back #(.BACK_BITS(BACK_BITS)) u_back (
        .clk  (clk),
        .rst  (rst),
        .step (st.front_tick),
        .last (st.back_last),
        .msb  (st.back_msb)
    );

    dmp_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode),
        .boundary (boundary),
        .mode_q   (mode_q)
    );

    assign div_clk  = st.back_msb;
    assign tc_pulse = boundary;
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker
    import dmp_pkg::*;
#(
    parameter int unsigned NORM_DIV    = 4,
    parameter int unsigned ALT_DIV     = 5,
    parameter bit          ALT_ON_MODE = 1'b1,
    parameter int unsigned BACK_BITS   = 5
) (
    input logic clk,
    input logic rst,
    input logic mode,
    input logic mode_q,
    input logic div_clk,
    input logic tc_pulse
);
    localparam int unsigned MAXLEN = max_of(NORM_DIV, ALT_DIV) << BACK_BITS;
    localparam int unsigned PW     = $clog2(MAXLEN + 2);
    localparam int unsigned HALF   = NORM_DIV << (BACK_BITS - 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] exp_last;

    always_ff @(posedge clk) begin
        if (rst || tc_pulse)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    assign exp_last = PW'(period_cycles(NORM_DIV, ALT_DIV, BACK_BITS, ALT_ON_MODE, mode_q) - 1);

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> (pcnt == exp_last)); // R1, R2, R3
    AST_RISE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk) |-> (pcnt == PW'(HALF))); // R4
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !tc_pulse |=> $stable(mode_q)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!div_clk && !tc_pulse)); // R6
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse); // R7
    AST_DIV_LOW_START: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !div_clk); // R8

    logic unused_mode;
    assign unused_mode = mode;
endmodule

bind dual_mod_prescaler dmp_checker #(
    .NORM_DIV(NORM_DIV), .ALT_DIV(ALT_DIV),
    .ALT_ON_MODE(ALT_ON_MODE), .BACK_BITS(BACK_BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .mode_q   (mode_q),
    .div_clk  (div_clk),
    .tc_pulse (tc_pulse)
);

// File: tb/dual_mod_prescaler_test.sv
`timescale 1ns/100ps
module dual_mod_prescaler_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic [1:0] dclk;
    logic [1:0] tc;

    int cmp = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_mod_prescaler uut (
        .clk(clk), .rst(rst), .mode(mode), .div_clk(dclk[0]), .tc_pulse(tc[0])
    );

    dual_mod_prescaler #(.NORM_DIV(4), .ALT_DIV(3), .ALT_ON_MODE(1'b0), .BACK_BITS(2)) uut_s (
        .clk(clk), .rst(rst), .mode(mode), .div_clk(dclk[1]), .tc_pulse(tc[1])
    );

    // Expected lengths taken from R1/R2 (index 0) and R3 (index 1).
    function automatic int exp_len(input int k, input logic m);
        if (k == 0) return m ? 129 : 128;
        return m ? 16 : 15;
    endfunction

    function automatic int half_of(input int k);
        return (k == 0) ? 64 : 8;
    endfunction

    int   cnt     [2];
    logic emode   [2];
    logic pdiv    [2];
    bit   chg     [2];
    bit   after_r [2];
    int   periods [2];
    logic last_mode;

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                cnt[k] = 0; emode[k] = mode; pdiv[k] = 1'b0;
                chg[k] = 1'b0; after_r[k] = 1'b1;
            end else begin
                cnt[k]++;
                if (mode != last_mode) chg[k] = 1'b1;
                if (tc[k]) begin
                    cmp++;
                    if (cnt[k] != exp_len(k, emode[k])) begin
                        bad++;
                        $display("FAIL %s%s%s period length (unit %0d): got %0d expected %0d",
                            (k == 1) ? "R3" : (emode[k] ? "R2" : "R1"),
                            chg[k] ? " R5" : "", after_r[k] ? " R6" : "",
                            k, cnt[k], exp_len(k, emode[k]));
                    end
                    cnt[k] = 0; emode[k] = mode; chg[k] = 1'b0; after_r[k] = 1'b0;
                    periods[k]++;
                end else if (cnt[k] == exp_len(k, emode[k])) begin
                    cmp++; bad++;
                    $display("FAIL R7 missing terminal pulse (unit %0d): got 0 expected 1 at cycle %0d",
                        k, cnt[k]);
                end
                if (dclk[k] && !pdiv[k]) begin
                    cmp++;
                    if (cnt[k] != half_of(k) + 1) begin
                        bad++;
                        $display("FAIL R4 divided clock rise offset (unit %0d): got %0d expected %0d",
                            k, cnt[k], half_of(k) + 1);
                    end
                end
                if (!dclk[k] && pdiv[k]) begin
                    cmp++;
                    if (cnt[k] != 1) begin
                        bad++;
                        $display("FAIL R8 divided clock fall (unit %0d): got cycle %0d expected 1", k, cnt[k]);
                    end
                end
                pdiv[k] = dclk[k];
            end
        end
        last_mode = mode;
    end

    task automatic do_reset(input logic m);
        rst = 1'b1;
        mode = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            cmp++;
            if (dclk[k] !== 1'b0 || tc[k] !== 1'b0) begin
                bad++;
                $display("FAIL R6 reset outputs (unit %0d): got div=%b tc=%b expected div=0 tc=0",
                    k, dclk[k], tc[k]);
            end
        end
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    endtask

    initial begin
        void'($urandom(32'h5eed_0c1a));
        last_mode = 1'b0;
        periods[0] = 0; periods[1] = 0;

        // R1, R6: mode 0 from reset, several periods
        do_reset(1'b0);
        run(400);
        // R2: switch mid-period, takes effect next boundary (R5)
        mode = 1'b1;
        run(420);
        // R5: change right after a boundary of the default unit
        @(negedge clk); while (!tc[0]) @(negedge clk);
        @(posedge clk); #1 mode = 1'b0;
        run(300);
        // R6: reset in the middle of a period with mode 1
        run(37);
        do_reset(1'b1);
        run(300);
        do_reset(1'b0);

        // random mode changes and occasional resets
        for (int n = 0; n < 40000; n++) begin
            @(posedge clk); #1;
            if ($urandom_range(0, 199) < 3) mode = ~mode;
            else if ($urandom_range(0, 9999) < 2) do_reset(1'($urandom_range(0, 1)));
        end
        run(200);

        for (int k = 0; k < 2; k++) begin
            cmp++;
            if (periods[k] < 100) begin
                bad++;
                $display("FAIL R7 too few terminal pulses (unit %0d): got %0d expected at least 100",
                    k, periods[k]);
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired: got hang expected completion");
            summary();
            $finish;
        end
    end
endmodule